// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words in the common single-precision layout. The layout has one sign bit at the top, then an 8-bit biased exponent, then a 23-bit stored fraction with an implied leading one. The block XORs the signs. It adds the biased exponents in a log-depth generate/propagate prefix adder and takes the bias back out. It multiplies the two 24-bit significands into a 48-bit product and normalizes that product by at most one place. The fraction is truncated and never rounded.

A classifier looks at both operands and at the normalized exponent. It sorts every case into one of these outcomes: an ordinary result, a signed zero, a signed infinity, or the canonical quiet NaN. It raises one of three flags when the result came from an invalid operation, an exponent overflow or an exponent underflow. A parameter chooses between a purely combinational result and a result held in one output register stage.

Top module: `fp32_mult`

## Requirements
- R1: For normal operands the result is sign XOR, exponent `eA + eB - 127` (plus normalization) and a truncated 23-bit fraction; -19.0 (0xC1980000) times 9.5 (0x41180000) yields 0xC3348000 (-180.5).
- R2: The result sign bit (bit 31) equals the XOR of the operand sign bits for every result that is not NaN, including zero and infinity results.
- R3: When bit 47 of the 48-bit significand product is set, the exponent rises by one and the fraction is product bits 46..24; otherwise the fraction is bits 45..23 and the exponent is unchanged (1.5 x 1.5 = 0x40100000).
- R4: Product bits below the selected fraction are discarded (truncation); 0x3F800001 x 0x3FC00000 yields 0x3FC00001.
- R5: Results whose normalized exponent lands exactly on 1 or on 254 are delivered as ordinary numbers with no flag.
- R6: A normalized exponent above 254 from finite nonzero operands gives infinity (exponent 0xFF, fraction 0) with the XOR sign and sets overflowFlag.
- R7: A normalized exponent below 1 from finite nonzero operands gives zero with the XOR sign and sets underflowFlag.
- R8: An operand with exponent field 0 (zero or denormal) is treated as zero: if the other operand is finite, the result is a signed zero and no flag is raised.
- R9: An infinity operand (exponent 0xFF, fraction 0) times a finite nonzero operand or an infinity gives a signed infinity and no flag.
- R10: A NaN operand (exponent 0xFF, nonzero fraction), or infinity times zero, gives 0x7FC00000 and sets invalidFlag.
- R11: The flags are {invalidFlag, overflowFlag, underflowFlag}, and at most one of them is set at a time.
- R12: With REG_OUT=1, the outputs show the result one clock edge after the operands are applied, and reset (rstN low) holds them at zero. With REG_OUT=0, the outputs follow the operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| prod | output | 32 | Product word |
| invalidFlag | output | 1 | Result is the canonical NaN from an invalid operation |
| overflowFlag | output | 1 | Exponent overflowed to infinity |
| underflowFlag | output | 1 | Exponent underflowed to zero |

## Verification
The bench builds two copies of the block with the default 8-bit exponent and 23-bit fraction. One copy has REG_OUT=1 and the other has REG_OUT=0, and both receive every operand pair. Comparing them against the same expected word checks the one-edge latency and the reset value of the registered variant, and checks that the combinational variant updates in the same cycle. The default widths let hand-derived encodings reach both normalization paths, the exponent limits 1 and 254, and their overflow and underflow neighbours.

// File: rtl/fp32_mult_pkg.sv
package fp32_mult_pkg;

  // Strobes from the classifier that pick the datapath's final word.
  typedef struct packed {
    logic selNan;
    logic selInf;
    logic selZero;
  } fmStrobe_t;

endpackage

// File: rtl/fp32_prefix_add.sv
// Parallel-prefix (Kogge-Stone style) adder with carry-in.
module fp32_prefix_add #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] propBit;
  logic [W-1:0] carryIn;

  always_comb begin
    logic [W-1:0] gCur, pCur, gNxt, pNxt;
    propBit = a ^ b;
    gCur    = a & b;
    pCur    = propBit;
    // carry-in folded into the bit-0 generate term
    gCur[0] = gCur[0] | (pCur[0] & cin);
    for (int lv = 0; lv < LVL; lv++) begin
      gNxt = gCur;
      pNxt = pCur;
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << lv)) begin
          gNxt[i] = gCur[i] | (pCur[i] & gCur[i - (1 << lv)]);
          pNxt[i] = pCur[i] & pCur[i - (1 << lv)];
        end
      end
      gCur = gNxt;
      pCur = pNxt;
    end
    carryIn = {gCur[W-2:0], cin};
  end

  assign sum = propBit ^ carryIn;

endmodule

// File: rtl/fp32_mult_ctrl.sv
// Special-case classifier: decides the output class and the flags.
module fp32_mult_ctrl
  import fp32_mult_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int EW = EXP_W + 2
) (
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  input  logic [EW-1:0]    expNorm,
  output fmStrobe_t        strobe,
  output logic             invalidFlag,
  output logic             overflowFlag,
  output logic             underflowFlag
);
  localparam int EXP_MAX = (1 << EXP_W) - 2;

  logic aZero, aInf, aNan, bZero, bInf, bNan;
  logic anyNan, anyInf, anyZero;
  logic expHigh, expLow;

  always_comb begin
    aZero = (magA[MAG_W-1 -: EXP_W] == '0);
    bZero = (magB[MAG_W-1 -: EXP_W] == '0);
    aInf  = (magA[MAG_W-1 -: EXP_W] == '1) && (magA[FRAC_W-1:0] == '0);
    bInf  = (magB[MAG_W-1 -: EXP_W] == '1) && (magB[FRAC_W-1:0] == '0);
    aNan  = (magA[MAG_W-1 -: EXP_W] == '1) && (magA[FRAC_W-1:0] != '0);
    bNan  = (magB[MAG_W-1 -: EXP_W] == '1) && (magB[FRAC_W-1:0] != '0);

    anyNan  = aNan || bNan || (aInf && bZero) || (bInf && aZero);
    anyInf  = !anyNan && (aInf || bInf);
    anyZero = !anyNan && !anyInf && (aZero || bZero);

    expHigh = $signed(expNorm) > $signed(EW'(EXP_MAX));
    expLow  = $signed(expNorm) < $signed(EW'(1));

    invalidFlag   = anyNan;
    overflowFlag  = !anyNan && !anyInf && !anyZero && expHigh;
    underflowFlag = !anyNan && !anyInf && !anyZero && expLow;

    strobe.selNan  = anyNan;
    strobe.selInf  = anyInf || overflowFlag;
    strobe.selZero = anyZero || underflowFlag;
  end

endmodule

// File: rtl/fp32_mult_dp.sv
// Arithmetic path: sign, exponent adders, significand product, normalize, pack.
module fp32_mult_dp
  import fp32_mult_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  localparam int TOP = EXP_W + FRAC_W,
  localparam int EW = EXP_W + 2
) (
  input  logic [TOP:0]   opA,
  input  logic [TOP:0]   opB,
  input  fmStrobe_t      strobe,
  output logic [EW-1:0]  expNorm,
  output logic [TOP:0]   prodWord
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int PW = 2 * SIG_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EW-1:0] NEG_BIAS = EW'((1 << EW) - BIAS);

  logic             signOut;
  logic [SIG_W-1:0] sigA, sigB;
  logic [PW-1:0]    product;
  logic             normHi;
  logic [FRAC_W-1:0] fracOut;
  logic [EW-1:0]    expSum;
  logic [FRAC_W-1:0] unusedLow;

  assign signOut = opA[TOP] ^ opB[TOP];
  assign sigA    = {1'b1, opA[FRAC_W-1:0]};
  assign sigB    = {1'b1, opB[FRAC_W-1:0]};
  assign product = PW'(sigA) * PW'(sigB);
  assign normHi  = product[PW-1];
  assign fracOut = normHi ? product[PW-2 -: FRAC_W] : product[PW-3 -: FRAC_W];
  assign unusedLow = product[FRAC_W-1:0];

  fp32_prefix_add #(.W(EW)) u_expSum (
    .a   ({2'b00, opA[TOP-1 -: EXP_W]}),
    .b   ({2'b00, opB[TOP-1 -: EXP_W]}),
    .cin (1'b0),
    .sum (expSum)
  );

  // bias removal, with the normalization step entering as carry-in
  fp32_prefix_add #(.W(EW)) u_expBias (
    .a   (expSum),
    .b   (NEG_BIAS),
    .cin (normHi),
    .sum (expNorm)
  );

  always_comb begin
    if (strobe.selNan)
      prodWord = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    else if (strobe.selInf)
      prodWord = {signOut, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (strobe.selZero)
      prodWord = {signOut, {TOP{1'b0}}};
    else
      prodWord = {signOut, expNorm[EXP_W-1:0], fracOut};
  end

endmodule

// File: rtl/fp32_mult.sv
module fp32_mult
  import fp32_mult_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  output logic [EXP_W+FRAC_W:0]   prod,
  output logic                    invalidFlag,
  output logic                    overflowFlag,
  output logic                    underflowFlag
);
  localparam int TOP = EXP_W + FRAC_W;
  localparam int EW = EXP_W + 2;

  fmStrobe_t   strobe;
  logic [EW-1:0] expNorm;
  logic [TOP:0]  prodComb;
  logic          invC, ovfC, unfC;

  fp32_mult_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .expNorm  (expNorm),
    .prodWord (prodComb)
  );

  fp32_mult_ctrl #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ctrl (
    .magA          (opA[TOP-1:0]),
    .magB          (opB[TOP-1:0]),
    .expNorm       (expNorm),
    .strobe        (strobe),
    .invalidFlag   (invC),
    .overflowFlag  (ovfC),
    .underflowFlag (unfC)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prod          <= '0;
          invalidFlag   <= 1'b0;
          overflowFlag  <= 1'b0;
          underflowFlag <= 1'b0;
        end else begin
          prod          <= prodComb;
          invalidFlag   <= invC;
          overflowFlag  <= ovfC;
          underflowFlag <= unfC;
        end
      end
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk     = clk ^ rstN;
      assign prod          = prodComb;
      assign invalidFlag   = invC;
      assign overflowFlag  = ovfC;
      assign underflowFlag = unfC;
    end
  endgenerate

endmodule

// File: rtl/fp32_mult_chk.sv
module fp32_mult_chk #(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [EXP_W+FRAC_W:0] opA,
  input logic [EXP_W+FRAC_W:0] opB,
  input logic [EXP_W+FRAC_W:0] prod,
  input logic                  invalidFlag,
  input logic                  overflowFlag,
  input logic                  underflowFlag
);
  localparam int TOP = EXP_W + FRAC_W;

  logic signNow, nanNow, signDly, nanDly, signRef, nanRef;

  assign signNow = opA[TOP] ^ opB[TOP];
  assign nanNow  = ((opA[TOP-1 -: EXP_W] == '1) && (opA[FRAC_W-1:0] != '0)) ||
                   ((opB[TOP-1 -: EXP_W] == '1) && (opB[FRAC_W-1:0] != '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signDly <= 1'b0;
      nanDly  <= 1'b0;
    end else begin
      signDly <= signNow;
      nanDly  <= nanNow;
    end
  end

  assign signRef = REG_OUT ? signDly : signNow;
  assign nanRef  = REG_OUT ? nanDly  : nanNow;

  // R10
  invalid_canon_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> prod == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}});
  // R10
  nan_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    nanRef |-> invalidFlag);
  // R6
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> prod[TOP-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
  // R7
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |-> prod[TOP-1:0] == '0);
  // R11
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({invalidFlag, overflowFlag, underflowFlag}));
  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    !invalidFlag |-> prod[TOP] == signRef);

endmodule

bind fp32_mult fp32_mult_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .opA           (opA),
  .opB           (opB),
  .prod          (prod),
  .invalidFlag   (invalidFlag),
  .overflowFlag  (overflowFlag),
  .underflowFlag (underflowFlag)
);

// File: tb/fp32_mult_bench.sv
`timescale 1ns/1ps
module fp32_mult_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] prodR, prodC;
  logic invR, ovfR, unfR, invC, ovfC, unfC;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp32_mult #(.REG_OUT(1'b1)) u_fp32_mult (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .prod(prodR),
    .invalidFlag(invR), .overflowFlag(ovfR), .underflowFlag(unfR));

  fp32_mult #(.REG_OUT(1'b0)) u_fp32_mult_comb (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .prod(prodC),
    .invalidFlag(invC), .overflowFlag(ovfC), .underflowFlag(unfC));

  task automatic cmp(input string req, input string what,
                     input logic [34:0] got, input logic [34:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // flags argument order {invalid, overflow, underflow}
  task automatic runCase(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] expP, input logic [2:0] expF);
    @(negedge clk);
    opA = a;
    opB = b;
    #1;
    cmp(req, "comb", {invC, ovfC, unfC, prodC}, {expF, expP});
    @(posedge clk);
    #2;
    cmp(req, "reg", {invR, ovfR, unfR, prodR}, {expF, expP});
  endtask

  task automatic testReset();
    opA = 32'h3F800000;
    opB = 32'h40000000;
    @(posedge clk);
    #2;
    // R12 reset holds registered outputs at zero
    cmp("R12", "reset", {invR, ovfR, unfR, prodR}, 35'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testNormal();
    runCase("R1", 32'hC1980000, 32'h41180000, 32'hC3348000, 3'b000);
    runCase("R1", 32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000);
    runCase("R2", 32'hC0000000, 32'hC0400000, 32'h40C00000, 3'b000);
    runCase("R2", 32'h40000000, 32'hC0400000, 32'hC0C00000, 3'b000);
    runCase("R3", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000);
    runCase("R4", 32'h3F800001, 32'h3FC00000, 32'h3FC00001, 3'b000);
    runCase("R4", 32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000);
    runCase("R4", 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 3'b000);
  endtask

  task automatic testRange();
    runCase("R5", 32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000);
    runCase("R5", 32'h00800000, 32'h3F800000, 32'h00800000, 3'b000);
    runCase("R6", 32'h7F000000, 32'h40000000, 32'h7F800000, 3'b010);
    runCase("R6", 32'hFF000000, 32'h40000000, 32'hFF800000, 3'b010);
    runCase("R7", 32'h00800000, 32'h3F000000, 32'h00000000, 3'b001);
    runCase("R7", 32'h80800000, 32'h3F000000, 32'h80000000, 3'b001);
  endtask

  task automatic testSpecial();
    runCase("R8", 32'h00000000, 32'h40400000, 32'h00000000, 3'b000);
    runCase("R8", 32'h80000000, 32'h40400000, 32'h80000000, 3'b000);
    runCase("R8", 32'h00000001, 32'h40000000, 32'h00000000, 3'b000);
    runCase("R8", 32'h00000000, 32'h7F000000, 32'h00000000, 3'b000);
    runCase("R9", 32'h7F800000, 32'h40000000, 32'h7F800000, 3'b000);
    runCase("R9", 32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000);
    runCase("R9", 32'hFF800000, 32'h7F000000, 32'hFF800000, 3'b000);
    runCase("R10", 32'h7F800000, 32'h00000000, 32'h7FC00000, 3'b100);
    runCase("R10", 32'h7FC12345, 32'h3F800000, 32'h7FC00000, 3'b100);
    runCase("R10", 32'hFF800001, 32'h7F800000, 32'h7FC00000, 3'b100);
  endtask

  task automatic testLatency();
    runCase("R12", 32'h40000000, 32'h40000000, 32'h40800000, 3'b000);
    @(negedge clk);
    opA = 32'h3FC00000;
    opB = 32'h3FC00000;
    #1;
    // R12 registered copy still shows previous result, combinational is new
    cmp("R12", "hold", {invR, ovfR, unfR, prodR}, {3'b000, 32'h40800000});
    cmp("R12", "same-cycle", {invC, ovfC, unfC, prodC}, {3'b000, 32'h40100000});
    // R11 flags mutually exclusive over a flagged case
    runCase("R11", 32'h7F000000, 32'h7F000000, 32'h7F800000, 3'b010);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testNormal();
    testRange();
    testSpecial();
    testLatency();
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule